// File: doc/BRIEF.md
# Fixed-point power droop controller

This block turns filtered estimates of an inverter's active and reactive power into two references: an angular-frequency reference and a peak-voltage reference. Each power input runs through a moving-average filter that takes in a new value on every sample strobe. On each slow update strobe, the filtered value is compared with a setpoint. The difference is scaled by a droop gain, rounded back to the data format, saturated and then clamped. The clamped correction is subtracted from a fixed nominal value. Raising active power therefore lowers the frequency reference, and raising reactive power lowers the voltage reference.

All data is 18-bit signed fixed point with 7 fractional bits, so one LSB is 1/128. The gains are unsigned 18-bit values with 17 fractional bits. A small write port loads the two setpoints and the two gains. Between update strobes the outputs hold their last value. The default nominals are 48255 LSB (about 120π rad/s) and 20817 LSB (about 162.6 V peak).

Top module: `droop_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `omega_o` = 48255, `volt_o` = 20817 and `valid_o` = 0. Reset empties both filter windows, sets both setpoints to 0 and sets the gains to 249 (frequency) and 2136 (voltage).
- R2: `valid_o` is high for exactly the cycles that follow a cycle with `tick_i` high. The outputs change only in those cycles and hold their value at all other times.
- R3: On a tick, `omega_o` becomes 48255 − Cf. Cf is the correction computed from the filtered active power minus the active-power setpoint, multiplied by the frequency gain.
- R4: On a tick, `volt_o` becomes 20817 − Cv. Cv is computed the same way from the filtered reactive power, the reactive-power setpoint and the voltage gain.
- R5: The frequency correction Cf is clamped to the range [−965, +965] LSB.
- R6: The voltage correction Cv is clamped to the range [−1086, +1086] LSB.
- R7: Each filter output is the floor of the sum of the 8 most recent samples divided by 8. Window slots not yet filled since reset count as 0.
- R8: `p_i` and `q_i` enter the filters only in cycles where `smp_i` is high. At all other times their values have no effect.
- R9: A write with `cfg_we_i` high stores `cfg_data_i` into the register chosen by `cfg_sel_i`: 0 = active-power setpoint, 1 = reactive-power setpoint, 2 = frequency gain, 3 = voltage gain. The new value is used from the next tick onward. A tick in the same cycle as the write still uses the old value.
- R10: The product of error and gain is rounded to the data format by adding 2^16 and then shifting right arithmetically by 17 bits. This rounds half up. The result is saturated to 18 bits before the clamp is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 1 | Sample strobe for the power inputs |
| p_i | input | 18 | Active-power estimate, signed, 7 fractional bits |
| q_i | input | 18 | Reactive-power estimate, signed, 7 fractional bits |
| tick_i | input | 1 | Droop update strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_data_i | input | 18 | Configuration write data |
| omega_o | output | 18 | Angular-frequency reference |
| volt_o | output | 18 | Peak-voltage reference |
| valid_o | output | 1 | Pulses high for one cycle after each update |

## Verification
Small positive powers with zero setpoints exercise the unclamped scaling on both paths. Large positive and large negative powers combined with large gains push each correction into its two clamp limits. Power values near the setpoint with a gain of one half land exactly on the rounding boundary, in both signs, which tells a half-up rounding apart from a truncation or a symmetric rounding. Sample sequences that change part-way through a window, input changes while no sample strobe is given, and a write in the same cycle as a tick separate the filter history, the sample gating and the configuration timing from one another.

// File: rtl/droop_pkg.sv
package droop_pkg;

    localparam int DW = 18;
    localparam int PW = 2 * DW + 2;

    typedef logic signed [DW-1:0] fx_t;
    typedef logic        [DW-1:0] gain_t;

    typedef enum logic [1:0] {
        CFG_PSET  = 2'd0,
        CFG_QSET  = 2'd1,
        CFG_MGAIN = 2'd2,
        CFG_NGAIN = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        fx_t   p_set;
        fx_t   q_set;
        gain_t m_gain;
        gain_t n_gain;
    } droop_cfg_t;

    function automatic fx_t sat_fx(input logic signed [PW-1:0] v);
        logic signed [PW-1:0] hi;
        logic signed [PW-1:0] lo;
        hi = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
        lo = -hi - PW'(1);
        if (v > hi)      sat_fx = hi[DW-1:0];
        else if (v < lo) sat_fx = lo[DW-1:0];
        else             sat_fx = v[DW-1:0];
    endfunction

endpackage

// File: rtl/droop_cfg.sv
module droop_cfg
    import droop_pkg::*;
#(
    parameter int M_RST = 249,
    parameter int N_RST = 2136
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  cfg_sel_e   sel,
    input  fx_t        data,
    output droop_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.p_set  <= '0;
            cfg.q_set  <= '0;
            cfg.m_gain <= gain_t'(M_RST);
            cfg.n_gain <= gain_t'(N_RST);
        end else if (we) begin
            case (sel)
                CFG_PSET:  cfg.p_set  <= data;
                CFG_QSET:  cfg.q_set  <= data;
                CFG_MGAIN: cfg.m_gain <= gain_t'(data);
                CFG_NGAIN: cfg.n_gain <= gain_t'(data);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/droop_avg.sv
module droop_avg
    import droop_pkg::*;
#(
    parameter int LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic smp,
    input  fx_t  x,
    output fx_t  avg
);
    localparam int DEPTH = 1 << LOG2;
    localparam int SW    = DW + LOG2;

    fx_t                  line [DEPTH];
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] x_ext;
    logic signed [SW-1:0] old_ext;
    logic signed [SW-1:0] avg_w;

    assign x_ext   = SW'(x);
    assign old_ext = SW'(line[DEPTH-1]);
    assign avg_w   = sum >>> LOG2;
    assign avg     = avg_w[DW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else if (smp) begin
            sum <= sum + x_ext - old_ext;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst) begin
                    line[i] <= '0;
                end else if (smp) begin
                    if (i == 0) line[i] <= x;
                    else        line[i] <= line[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/droop_law.sv
module droop_law
    import droop_pkg::*;
#(
    parameter int GF  = 17,
    parameter int LIM = 965,
    parameter int NOM = 48255
) (
    input  fx_t   avg,
    input  fx_t   setp,
    input  gain_t gain,
    output fx_t   ref_nx
);
    localparam logic signed [PW-1:0] HALF  = PW'(64'sd1 <<< (GF - 1));
    localparam fx_t                  LIM_P = fx_t'(LIM);
    localparam fx_t                  LIM_N = fx_t'(-LIM);
    localparam fx_t                  NOM_V = fx_t'(NOM);

    logic signed [DW:0]   err;
    logic signed [DW:0]   g_s;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    fx_t                  corr_s;
    fx_t                  corr_c;

    always_comb begin
        err  = (DW+1)'(avg) - (DW+1)'(setp);
        g_s  = $signed({1'b0, gain});
        prod = PW'(err) * PW'(g_s);
        rnd  = (prod + HALF) >>> GF;
        corr_s = sat_fx(rnd);
        if (corr_s > LIM_P)      corr_c = LIM_P;
        else if (corr_s < LIM_N) corr_c = LIM_N;
        else                     corr_c = corr_s;
        ref_nx = NOM_V - corr_c;
    end
endmodule

// File: rtl/droop_ctrl.sv
module droop_ctrl
    import droop_pkg::*;
#(
    parameter int AVG_LOG2  = 3,
    parameter int GAIN_FRAC = 17,
    parameter int OMEGA_NOM = 48255,
    parameter int VOLT_NOM  = 20817,
    parameter int OMEGA_LIM = 965,
    parameter int VOLT_LIM  = 1086,
    parameter int M_RST     = 249,
    parameter int N_RST     = 2136
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_i,
    input  logic [17:0] p_i,
    input  logic [17:0] q_i,
    input  logic        tick_i,
    input  logic        cfg_we_i,
    input  logic [1:0]  cfg_sel_i,
    input  logic [17:0] cfg_data_i,
    output logic [17:0] omega_o,
    output logic [17:0] volt_o,
    output logic        valid_o
);
    droop_cfg_t cfg;
    fx_t        p_avg, q_avg;
    fx_t        omega_nx, volt_nx;

    droop_cfg #(.M_RST(M_RST), .N_RST(N_RST)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we_i),
        .sel(cfg_sel_e'(cfg_sel_i)), .data(fx_t'(cfg_data_i)), .cfg(cfg)
    );

    droop_avg #(.LOG2(AVG_LOG2)) u_pavg (
        .clk(clk), .rst(rst), .smp(smp_i), .x(fx_t'(p_i)), .avg(p_avg)
    );

    droop_avg #(.LOG2(AVG_LOG2)) u_qavg (
        .clk(clk), .rst(rst), .smp(smp_i), .x(fx_t'(q_i)), .avg(q_avg)
    );

    droop_law #(.GF(GAIN_FRAC), .LIM(OMEGA_LIM), .NOM(OMEGA_NOM)) u_flaw (
        .avg(p_avg), .setp(cfg.p_set), .gain(cfg.m_gain), .ref_nx(omega_nx)
    );

    droop_law #(.GF(GAIN_FRAC), .LIM(VOLT_LIM), .NOM(VOLT_NOM)) u_vlaw (
        .avg(q_avg), .setp(cfg.q_set), .gain(cfg.n_gain), .ref_nx(volt_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            omega_o <= 18'(OMEGA_NOM);
            volt_o  <= 18'(VOLT_NOM);
            valid_o <= 1'b0;
        end else begin
            valid_o <= tick_i;
            if (tick_i) begin
                omega_o <= omega_nx;
                volt_o  <= volt_nx;
            end
        end
    end
endmodule

// File: rtl/droop_ctrl_chk.sv
module droop_ctrl_chk #(
    parameter int OMEGA_NOM = 48255,
    parameter int VOLT_NOM  = 20817,
    parameter int OMEGA_LIM = 965,
    parameter int VOLT_LIM  = 1086
) (
    input logic        clk,
    input logic        rst,
    input logic        tick_i,
    input logic [17:0] omega_o,
    input logic [17:0] volt_o,
    input logic        valid_o
);
    localparam logic signed [17:0] F_HI = 18'(OMEGA_NOM + OMEGA_LIM);
    localparam logic signed [17:0] F_LO = 18'(OMEGA_NOM - OMEGA_LIM);
    localparam logic signed [17:0] V_HI = 18'(VOLT_NOM + VOLT_LIM);
    localparam logic signed [17:0] V_LO = 18'(VOLT_NOM - VOLT_LIM);

    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (omega_o == 18'(OMEGA_NOM) && volt_o == 18'(VOLT_NOM) && !valid_o));

    assert_valid_follows_tick_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o == $past(tick_i));

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(tick_i) |-> ($stable(omega_o) && $stable(volt_o)));

    assert_freq_clamp_R5: assert property (@(posedge clk) disable iff (rst)
        ($signed(omega_o) <= F_HI && $signed(omega_o) >= F_LO));

    assert_volt_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        ($signed(volt_o) <= V_HI && $signed(volt_o) >= V_LO));
endmodule

bind droop_ctrl droop_ctrl_chk #(
    .OMEGA_NOM(OMEGA_NOM), .VOLT_NOM(VOLT_NOM),
    .OMEGA_LIM(OMEGA_LIM), .VOLT_LIM(VOLT_LIM)
) u_chk (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .omega_o(omega_o), .volt_o(volt_o), .valid_o(valid_o)
);

// File: tb/sim_droop_ctrl.sv
module sim_droop_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_i = 1'b0;
    logic [17:0] p_i = '0;
    logic [17:0] q_i = '0;
    logic        tick_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [17:0] cfg_data_i = '0;
    logic [17:0] omega_o;
    logic [17:0] volt_o;
    logic        valid_o;

    always #10 clk = ~clk;

    droop_ctrl u0 (
        .clk(clk), .rst(rst), .smp_i(smp_i), .p_i(p_i), .q_i(q_i),
        .tick_i(tick_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_data_i(cfg_data_i), .omega_o(omega_o), .volt_o(volt_o),
        .valid_o(valid_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int ph[8];
    int qh[8];
    int psp, qsp, mg, ng;
    int last_f = 48255;
    int last_v = 20817;

    typedef struct { int f; int v; string tag; } exp_t;
    exp_t sbq[$];

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int win_avg(int h[8]);
        longint s = 0;
        for (int i = 0; i < 8; i++) s += h[i];
        return int'(s >>> 3);
    endfunction

    function automatic int law(int a, int sp, int g, int lim, int nom);
        longint pr, r;
        pr = longint'(a - sp) * longint'(g);
        r  = (pr + 65536) >>> 17;
        if (r > 131071)  r = 131071;
        if (r < -131072) r = -131072;
        if (r > lim)  r = lim;
        if (r < -lim) r = -lim;
        return nom - int'(r);
    endfunction

    function automatic int s18(logic [17:0] v);
        return int'($signed(v));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin ph[i] = 0; qh[i] = 0; end
        psp = 0; qsp = 0; mg = 249; ng = 2136;
        last_f = 48255; last_v = 20817;
    endtask

    task automatic push_expected(string tag);
        exp_t e;
        e.f = law(win_avg(ph), psp, mg, 965, 48255);
        e.v = law(win_avg(qh), qsp, ng, 1086, 20817);
        e.tag = tag;
        last_f = e.f; last_v = e.v;
        sbq.push_back(e);
    endtask

    task automatic sample(int p, int q);
        smp_i = 1'b1; p_i = 18'(p); q_i = 18'(q);
        @(posedge clk); #2;
        smp_i = 1'b0;
        for (int i = 7; i > 0; i--) begin ph[i] = ph[i-1]; qh[i] = qh[i-1]; end
        ph[0] = p; qh[0] = q;
    endtask

    task automatic fill(int p, int q);
        for (int k = 0; k < 8; k++) sample(p, q);
    endtask

    task automatic cfg_apply(int sel, int val);
        case (sel)
            0: psp = val;
            1: qsp = val;
            2: mg = val;
            default: ng = val;
        endcase
    endtask

    task automatic cfg_write(int sel, int val);
        cfg_we_i = 1'b1; cfg_sel_i = 2'(sel); cfg_data_i = 18'(val);
        @(posedge clk); #2;
        cfg_we_i = 1'b0;
        cfg_apply(sel, val);
    endtask

    task automatic tick(string tag);
        push_expected(tag);
        tick_i = 1'b1;
        @(posedge clk); #2;
        tick_i = 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic tick_with_write(string tag, int sel, int val);
        push_expected(tag);
        tick_i = 1'b1;
        cfg_we_i = 1'b1; cfg_sel_i = 2'(sel); cfg_data_i = 18'(val);
        @(posedge clk); #2;
        tick_i = 1'b0; cfg_we_i = 1'b0;
        cfg_apply(sel, val);
        @(posedge clk); #2;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (sbq.size() == 0) begin
                check("R2 unexpected valid", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check({e.tag, " omega"}, s18(omega_o), e.f);
                check({e.tag, " volt"},  s18(volt_o),  e.v);
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (5) @(posedge clk);
        #2;
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check("R1 reset omega", s18(omega_o), 48255);
        check("R1 reset volt",  s18(volt_o),  20817);
        check("R1 reset valid", int'(valid_o), 0);
        @(posedge clk); #2;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_reset();
        @(posedge clk); #2;
        do_reset();

        // R1: filters start empty, defaults used
        tick("R1 empty filter");

        // R3 R4 R7: steady inputs within limits
        fill(1280, 640);
        tick("R3 R4 steady");

        // R7: partial window change
        sample(5120, -2560);
        sample(5120, -2560);
        sample(5120, -2560);
        tick("R7 partial window");

        // R2: hold between ticks, no valid
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 hold valid", int'(valid_o), 0);
        check("R2 hold omega", s18(omega_o), last_f);
        check("R2 hold volt",  s18(volt_o),  last_v);
        @(posedge clk); #2;

        // R8: inputs without strobe are ignored
        p_i = 18'(100000); q_i = 18'(-100000);
        repeat (4) @(posedge clk);
        #2;
        tick("R8 no strobe");

        // R9: setpoints
        cfg_write(0, 3000);
        cfg_write(1, -1500);
        tick("R9 setpoints");

        // R5: frequency clamp, both signs
        cfg_write(2, 100000);
        fill(128000, 0);
        tick("R5 clamp high power");
        fill(-128000, 0);
        tick("R5 clamp low power");

        // R6: voltage clamp, both signs
        cfg_write(3, 120000);
        fill(0, 120000);
        tick("R6 clamp high reactive");
        fill(0, -120000);
        tick("R6 clamp low reactive");

        // R10: rounding at the half boundary
        cfg_write(0, 0);
        cfg_write(1, 0);
        cfg_write(2, 65536);
        cfg_write(3, 65536);
        fill(1, -1);
        tick("R10 half round pos");
        fill(-1, 1);
        tick("R10 half round neg");
        fill(3, -3);
        tick("R10 half round odd");

        // R9: write in the same cycle as a tick uses the old value
        fill(2560, 2560);
        tick_with_write("R9 same cycle write", 2, 20000);
        tick("R9 next tick new gain");

        // R1: mid-run reset clears filters and configuration
        do_reset();
        tick("R1 cleared after reset");

        repeat (4) @(posedge clk);
        check("R2 queue drained", sbq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule